// File: doc/BRIEF.md
# Event Interrupt Controller

This block collects single-cycle event pulses from up to fourteen on-chip sources: display timing, four timers, a serial port, four DMA channels, a keypad and cartridge removal. It records each pulse as a sticky pending flag and drives one level-sensitive interrupt line toward the processor. Software works through three 16-bit registers on a simple peripheral bus. The first is a per-source enable mask. The second holds the pending flags, which software clears by writing ones. The third is a single master enable bit.

Each source also supplies an arm level, which stands for the enable bit that a peripheral keeps in its own registers. An event counts only while its source is armed. A pending flag leads to an interrupt only when it is also enabled in the mask and the master bit is on. Pending flags are recorded even while masked, so software can poll them. Acknowledging one source leaves the other flags untouched, so events that arrive together are not lost.

Source bit order: 0 vertical blank, 1 horizontal blank, 2 line-count match, 3 to 6 timers 0 to 3, 7 serial, 8 to 11 DMA 0 to 3, 12 keypad, 13 cartridge removal.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the enable, pending and master registers all read 0, and irqOut is 0.
- R2: A srcEvent pulse on bit i while srcArm[i] is 1 sets pending bit i at that clock edge, whatever the enable and master state.
- R3: A srcEvent pulse on bit i while srcArm[i] is 0 leaves pending bit i unchanged.
- R4: A bus write to the pending register at offset 0x202 clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If an armed event and a write-1 clear hit the same pending bit in the same cycle, the bit stays set.
- R6: irqOut is a register. It equals master & OR(enable & pending) as those registers stood one clock edge earlier.
- R7: While master bit 0 at offset 0x208 is 0, irqOut stays 0 whatever the enable and pending state.
- R8: The enable register at offset 0x200 stores write bits 13..0 and reads them back. Bits 15..14 of the enable and pending registers always read 0.
- R9: The master register stores only write bit 0, and a read of it returns that bit in bit 0 with bits 15..1 at 0.
- R10: A write to any offset other than 0x200, 0x202 and 0x208 changes no register, and a read of any other offset returns 0.
- R11: A write to the pending register never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational, valid while busSel=1 and busWr=0 |
| srcArm | input | 14 | Per-source arm level (the peripheral's own enable) |
| srcEvent | input | 14 | Per-source single-cycle event pulse |
| irqOut | output | 1 | Level interrupt request to the processor |

## Verification
A write or an armed event takes effect at the clock edge where it is sampled, so a read at the next falling edge already shows the new register value. irqOut lags those registers by one more edge. The bench checks irqOut twice: at the falling edge just after the stimulus edge, where it must still hold its old value, and one cycle later, where it must hold the new one. Reads are combinational, so the bench drives the address at a falling edge and samples the data a moment later, before the next rising edge. Every source bit is swept against all arm, enable and master combinations, and computed masks are used for the clear patterns.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned NUM_SRC = 14;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 10'h200;
  localparam logic [ADDR_W-1:0] OFS_PEND = 10'h202;
  localparam logic [ADDR_W-1:0] OFS_MASTER = 10'h208;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_ENABLE = 2'd1,
    RD_PEND = 2'd2,
    RD_MASTER = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrPend;
    logic wrMaster;
    rdSel_e rdSel;
  } ctlStrb_t;

endpackage

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
  import evt_irq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] EN_OFS = OFS_ENABLE,
  parameter logic [AW-1:0] PEND_OFS = OFS_PEND,
  parameter logic [AW-1:0] MSTR_OFS = OFS_MASTER
) (
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWr,
  input  logic [AW-1:0] busAddr,
  output ctlStrb_t strb
);

  logic hitEnable;
  logic hitPend;
  logic hitMaster;
  logic isWrite;
  logic isRead;

  assign hitEnable = (busAddr == EN_OFS);
  assign hitPend = (busAddr == PEND_OFS);
  assign hitMaster = (busAddr == MSTR_OFS);
  assign isWrite = busSel & busWr;
  assign isRead = busSel & ~busWr;

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (isWrite) begin
      strb.wrEnable = hitEnable;
      strb.wrPend = hitPend;
      strb.wrMaster = hitMaster;
    end
    if (isRead) begin
      if (hitEnable) strb.rdSel = RD_ENABLE;
      else if (hitPend) strb.rdSel = RD_PEND;
      else if (hitMaster) strb.rdSel = RD_MASTER;
    end
  end

  // R10: at most one register written per access, and none when no write
  p_one_write_r10 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEnable, strb.wrPend, strb.wrMaster}));

  p_no_wr_on_read_r10 : assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> !(strb.wrEnable | strb.wrPend | strb.wrMaster));

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = NUM_SRC
) (
  input  logic clk,
  input  logic rstN,
  input  ctlStrb_t strb,
  input  logic [DW-1:0] wdata,
  input  logic [NS-1:0] srcArm,
  input  logic [NS-1:0] srcEvent,
  output logic [DW-1:0] rdata,
  output logic irqOut
);

  localparam int unsigned PAD_W = DW - NS;

  logic [NS-1:0] enableQ;
  logic [NS-1:0] pendQ;
  logic [NS-1:0] pendD;
  logic masterQ;
  logic [NS-1:0] liveEvt;
  logic [NS-1:0] clrMask;
  logic unusedWdHigh;

  assign unusedWdHigh = ^wdata[DW-1:NS];
  assign liveEvt = srcEvent & srcArm;
  assign clrMask = strb.wrPend ? wdata[NS-1:0] : '0;

  // per-source pending cell: an armed event has priority over a clear
  for (genvar g = 0; g < NS; g++) begin : g_pend
    always_comb begin
      if (liveEvt[g]) pendD[g] = 1'b1;
      else if (clrMask[g]) pendD[g] = 1'b0;
      else pendD[g] = pendQ[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      enableQ <= '0;
      masterQ <= 1'b0;
    end else begin
      pendQ <= pendD;
      if (strb.wrEnable) enableQ <= wdata[NS-1:0];
      if (strb.wrMaster) masterQ <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else irqOut <= masterQ & (|(enableQ & pendQ));
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_ENABLE: rdata = {{PAD_W{1'b0}}, enableQ};
      RD_PEND: rdata = {{PAD_W{1'b0}}, pendQ};
      RD_MASTER: rdata = {{(DW-1){1'b0}}, masterQ};
      default: rdata = '0;
    endcase
  end

  // R4: every bit written as 1 with no event that cycle is now clear
  p_clear_hits_r4 : assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPend |=> ((pendQ & $past(clrMask & ~liveEvt)) == '0));

  // R4, R11: a bit that was pending and not cleared stays pending
  p_no_drop_r4 : assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pendQ & ~clrMask) & ~pendQ) == '0));

  // R5: an armed event always leaves its bit set
  p_set_wins_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (|liveEvt) |=> ((pendQ & $past(liveEvt)) == $past(liveEvt)));

  // R3, R11: nothing sets a bit unless an armed event hit it
  p_no_spurious_r3 : assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(liveEvt)) == '0));

  // R7: master off means no request one edge later
  p_master_gate_r7 : assert property (@(posedge clk) disable iff (!rstN)
    !masterQ |=> !irqOut);

  // R6: nothing enabled and pending means no request one edge later
  p_idle_low_r6 : assert property (@(posedge clk) disable iff (!rstN)
    ((enableQ & pendQ) == '0) |=> !irqOut);

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_SRC-1:0] srcArm,
  input  logic [NUM_SRC-1:0] srcEvent,
  output logic irqOut
);

  ctlStrb_t strb;

  evt_irq_ctl #(
    .AW(ADDR_W),
    .EN_OFS(OFS_ENABLE),
    .PEND_OFS(OFS_PEND),
    .MSTR_OFS(OFS_MASTER)
  ) u_ctl (
    .clk(clk),
    .rstN(rstN),
    .busSel(busSel),
    .busWr(busWr),
    .busAddr(busAddr),
    .strb(strb)
  );

  evt_irq_regs #(
    .DW(DATA_W),
    .NS(NUM_SRC)
  ) u_regs (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wdata(busWdata),
    .srcArm(srcArm),
    .srcEvent(srcEvent),
    .rdata(busRdata),
    .irqOut(irqOut)
  );

endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;

  localparam int NS = 14;
  localparam logic [15:0] ALL = 16'h3FFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic [9:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [NS-1:0] srcArm = '0;
  logic [NS-1:0] srcEvent = '0;
  logic irqOut;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcArm(srcArm), .srcEvent(srcEvent), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [15:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk);
    srcEvent = m;
    @(negedge clk);
    srcEvent = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] pat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(10'h200, rd); check("R1 enable", rd, 16'h0);
    busRead(10'h202, rd); check("R1 pending", rd, 16'h0);
    busRead(10'h208, rd); check("R1 master", rd, 16'h0);
    check("R1 irq", {15'd0, irqOut}, 16'h0);

    // R2 R3 R6 R7: sweep every source against arm/enable/master
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic arm, en, mst;
        logic [15:0] bitv;
        arm = c[0]; en = c[1]; mst = c[2];
        bitv = 16'h1 << s;
        busWrite(10'h202, 16'hFFFF);
        busWrite(10'h200, en ? bitv : 16'h0);
        busWrite(10'h208, {15'd0, mst});
        srcArm = arm ? ALL[NS-1:0] : ~bitv[NS-1:0];
        pulse(bitv[NS-1:0]);
        busRead(10'h202, rd);
        check(arm ? "R2 pending set" : "R3 unarmed ignored", rd, arm ? bitv : 16'h0);
        check("R6 irq lag", {15'd0, irqOut}, 16'h0);
        @(negedge clk);
        check(mst ? "R6 irq level" : "R7 master blocks", {15'd0, irqOut},
              {15'd0, arm & en & mst});
      end
    end

    // R7: dropping master removes an active request after two edges
    srcArm = ALL[NS-1:0];
    busWrite(10'h202, 16'hFFFF);
    busWrite(10'h200, 16'h0020);
    busWrite(10'h208, 16'h0001);
    pulse(14'h0020);
    @(negedge clk);
    check("R6 irq raised", {15'd0, irqOut}, 16'h1);
    busWrite(10'h208, 16'h0000);
    check("R7 irq old value", {15'd0, irqOut}, 16'h1);
    @(negedge clk);
    check("R7 irq dropped", {15'd0, irqOut}, 16'h0);
    // R6: clearing the pending flag removes the request
    busWrite(10'h208, 16'h0001);
    @(negedge clk);
    check("R6 irq back", {15'd0, irqOut}, 16'h1);
    busWrite(10'h202, 16'h0020);
    @(negedge clk);
    check("R6 irq after ack", {15'd0, irqOut}, 16'h0);

    // R4 R11: computed clear patterns against a full pending register
    for (int k = 0; k < 40; k++) begin
      pat = 16'((k * 16'h2B5 + 16'h1357) ^ (k << 9));
      pulse(ALL[NS-1:0]);
      busRead(10'h202, rd); check("R2 all pending", rd, ALL);
      busWrite(10'h202, pat);
      busRead(10'h202, rd); check("R4 w1c pattern", rd, ALL & ~pat);
      busWrite(10'h202, 16'h0);
      busRead(10'h202, rd); check("R11 zero write keeps", rd, ALL & ~pat);
      busWrite(10'h202, 16'hFFFF);
      busRead(10'h202, rd); check("R4 clear all", rd, 16'h0);
    end

    // R5: event and clear of same bit in same cycle, neighbour cleared
    for (int b = 0; b < NS; b++) begin
      logic [15:0] bitv;
      logic [15:0] nb;
      bitv = 16'h1 << b;
      nb = 16'h1 << ((b + 1) % NS);
      pulse(nb[NS-1:0]);
      @(negedge clk);
      busSel = 1'b1; busWr = 1'b1; busAddr = 10'h202; busWdata = bitv | nb;
      srcEvent = bitv[NS-1:0];
      @(negedge clk);
      busSel = 1'b0; busWr = 1'b0; srcEvent = '0;
      busRead(10'h202, rd); check("R5 set wins", rd, bitv);
      busWrite(10'h202, 16'hFFFF);
    end

    // R8 enable readback, R9 master readback
    busWrite(10'h200, 16'hFFFF);
    busRead(10'h200, rd); check("R8 enable all", rd, 16'h3FFF);
    busWrite(10'h200, 16'hA5C3);
    busRead(10'h200, rd); check("R8 enable pattern", rd, 16'h25C3);
    busWrite(10'h208, 16'hFFFE);
    busRead(10'h208, rd); check("R9 master bit0 low", rd, 16'h0);
    busWrite(10'h208, 16'hFFFF);
    busRead(10'h208, rd); check("R9 master bit0 only", rd, 16'h1);

    // R10: other offsets
    pulse(14'h1111);
    busWrite(10'h204, 16'hFFFF);
    busWrite(10'h203, 16'hFFFF);
    busWrite(10'h000, 16'h0000);
    busWrite(10'h209, 16'h0000);
    busRead(10'h200, rd); check("R10 enable kept", rd, 16'h25C3);
    busRead(10'h202, rd); check("R10 pending kept", rd, 16'h1111);
    busRead(10'h208, rd); check("R10 master kept", rd, 16'h1);
    busRead(10'h204, rd); check("R10 read other", rd, 16'h0);
    busRead(10'h201, rd); check("R10 read odd", rd, 16'h0);
    busRead(10'h3FF, rd); check("R10 read top", rd, 16'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule